// File: doc/BRIEF.md
# Host-to-CPU Word FIFO Bridge with Grouped Data Requests

This block carries 16-bit data words from a host processor to the DMA channel of a secondary CPU. The host sees a small register window. One register holds the intended transfer length in words. A data port accepts the words. A control/status register holds a run bit, a general-purpose routing bit, a sticky overflow flag and a read-only FULL flag. Words written through the data port are queued in a small FIFO. The DMA side is granted access to them only in groups: after every fourth accepted word, and only while the DMA channel reports the matching mode and the master DMA enable is on, the bridge lets the channel pop four more words and holds its request line high while any such words remain.

The DMA side loads its own transfer count. The count goes down by one for every word popped. The pop that takes it to zero ends the transfer. At that point the run bit drops by itself, the FIFO is emptied and a transfer-end flag is raised. If the loaded count differs from the host's length register, a one-cycle anomaly pulse is given, but the transfer runs on. A data-port write made while the run bit is clear is discarded and also flagged with a pulse. If the host clears the run bit early, the FIFO is flushed and any outstanding request is withdrawn.

Top module: `h2c_req_bridge`

## Requirements
- R1: A host write to offset 0x10 stores the transfer length, and a read of offset 0x10 returns it.
- R2: A host write to the data port at offset 0x12 is queued only while the run bit is set. When the run bit is clear the word is dropped, and `anom_nostart` is high for the cycle after the write.
- R3: Status bit 7 of offset 0x06 (FULL) is set once the FIFO holds DEPTH words and stays set until the FIFO is empty again. Host writes cannot change it.
- R4: A data request becomes pending after each accepted word whose running count since the last flush is a multiple of GROUP, provided `dma_mode_ok` and `dma_en` are high at that write. Each such group lets GROUP more words be popped. `dma_dreq` is high while poppable words remain, and `dma_data` presents the words in write order.
- R5: `dma_cnt_we` loads the DMA transfer count. Each granted pop lowers it by one, and its value is visible on `dma_count`.
- R6: The granted pop that takes the count from 1 to 0 clears the run bit, empties the FIFO, drops `dma_dreq` and sets `xfer_end`. `xfer_end` stays set until the next count load.
- R7: If a count load differs from the length register, `anom_len` is high for the following cycle, and the transfer still proceeds and completes normally.
- R8: A host write to offset 0x06 changes only the run bit (bit 0) and the routing bit (bit 1). The routing bit is driven on `rv_out`.
- R9: A data-port write made while the run bit and FULL are both set is dropped and sets the sticky overflow flag (status bit 6). That flag is cleared only when the run bit goes from 0 to 1.
- R10: Clearing the run bit while it is set flushes the FIFO and withdraws any pending request. Words written afterwards start from an empty FIFO.
- R11: A group completed while `dma_mode_ok` or `dma_en` is low grants no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hst_we | input | 1 | Host register write strobe |
| hst_addr | input | AW | Host register byte offset |
| hst_wdata | input | DW | Host write data |
| hst_rdata | output | DW | Host read data for `hst_addr` |
| dma_mode_ok | input | 1 | DMA channel is in the matching request mode |
| dma_en | input | 1 | Master DMA enable |
| dma_cnt_we | input | 1 | Load DMA transfer count |
| dma_cnt_wdata | input | DW | Transfer count value to load |
| dma_count | output | DW | Remaining DMA transfer count |
| dma_pop | input | 1 | DMA channel takes the word on `dma_data` |
| dma_dreq | output | 1 | Data request: granted words are waiting |
| dma_data | output | DW | Oldest queued word |
| xfer_end | output | 1 | Transfer ended normally |
| rv_out | output | 1 | Routing bit from the control register |
| anom_nostart | output | 1 | Pulse: data write discarded, run bit clear |
| anom_len | output | 1 | Pulse: loaded count differs from length |

## Verification
The bench builds the block with DEPTH 8 and GROUP 4, so that two complete groups exactly fill the FIFO. This puts the FULL latch, the overflow drop and the drain-to-empty release within reach of a short sequence. A count of 5 against 8 queued words places the count-zero completion in the middle of a second group, which exercises the flush of words that were queued but never popped. A scoreboard of accepted words, cleared whenever a flush is expected, shows that no stale or discarded word ever reaches `dma_data`.

// File: rtl/h2c_pkg.sv
package h2c_pkg;
   // status/control register bit positions
   localparam int GO_BIT   = 0;
   localparam int RV_BIT   = 1;
   localparam int OVF_BIT  = 6;
   localparam int FULL_BIT = 7;
endpackage

// File: rtl/h2c_fifo.sv
module h2c_fifo #(
   parameter int DW    = 16,
   parameter int DEPTH = 8,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int LW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic [LW-1:0] level
);
   logic [DW-1:0] mem [DEPTH];
   logic [PW-1:0] wr_ptr, rd_ptr, wr_nx, rd_nx;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wr_nx = wr_ptr + 1'b1;
         assign rd_nx = rd_ptr + 1'b1;
      end else begin : g_wrap
         assign wr_nx = (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
         assign rd_nx = (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      end
   endgenerate

   assign rdata = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push && !flush) mem[wr_ptr] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push) wr_ptr <= wr_nx;
         if (pop)  rd_ptr <= rd_nx;
         level <= level + LW'(push) - LW'(pop);
      end
   end
endmodule

// File: rtl/h2c_req.sv
module h2c_req #(
   parameter int DW    = 16,
   parameter int DEPTH = 8,
   parameter int GROUP = 4,
   localparam int GW   = $clog2(GROUP),
   localparam int KW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push_ok,
   input  logic          mode_ok,
   input  logic          dma_en,
   input  logic          pop_req,
   input  logic          cnt_we,
   input  logic [DW-1:0] cnt_wdata,
   output logic          pop_ok,
   output logic          dreq,
   output logic          done,
   output logic [DW-1:0] cnt_q
);
   logic [GW-1:0] grp_q;
   logic [KW-1:0] cred_q;
   logic          grant;

   assign grant  = push_ok && (grp_q == GW'(GROUP - 1)) && mode_ok && dma_en;
   assign dreq   = (cred_q != '0);
   assign pop_ok = pop_req && dreq;
   assign done   = pop_ok && !cnt_we && (cnt_q == DW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q  <= '0;
         cred_q <= '0;
      end else if (flush) begin
         grp_q  <= '0;
         cred_q <= '0;
      end else begin
         if (push_ok) grp_q <= grp_q + 1'b1;
         cred_q <= cred_q + (grant ? KW'(GROUP) : KW'(0)) - (pop_ok ? KW'(1) : KW'(0));
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          cnt_q <= '0;
      else if (cnt_we)                     cnt_q <= cnt_wdata;
      else if (pop_ok && cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/h2c_req_bridge.sv
module h2c_req_bridge
   import h2c_pkg::*;
#(
   parameter int DW    = 16,
   parameter int AW    = 6,
   parameter int DEPTH = 8,
   parameter int GROUP = 4,
   parameter logic [AW-1:0] CTL_OFS = 'h06,
   parameter logic [AW-1:0] LEN_OFS = 'h10,
   parameter logic [AW-1:0] DAT_OFS = 'h12,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hst_we,
   input  logic [AW-1:0] hst_addr,
   input  logic [DW-1:0] hst_wdata,
   output logic [DW-1:0] hst_rdata,
   input  logic          dma_mode_ok,
   input  logic          dma_en,
   input  logic          dma_cnt_we,
   input  logic [DW-1:0] dma_cnt_wdata,
   output logic [DW-1:0] dma_count,
   input  logic          dma_pop,
   output logic          dma_dreq,
   output logic [DW-1:0] dma_data,
   output logic          xfer_end,
   output logic          rv_out,
   output logic          anom_nostart,
   output logic          anom_len
);
   generate
      if (GROUP < 2 || (GROUP & (GROUP - 1)) != 0) begin : g_bad_group
         $error("GROUP must be a power of two of at least 2");
      end
      if (DEPTH < GROUP || (DEPTH % GROUP) != 0) begin : g_bad_depth
         $error("DEPTH must be a nonzero multiple of GROUP");
      end
      if (DW <= FULL_BIT) begin : g_bad_dw
         $error("DW too narrow for status bits");
      end
   endgenerate

   logic [DW-1:0] len_q;
   logic go_q, rv_q, ovf_q, full_q, xend_q, anom_ns_q, anom_len_q;
   logic wr_ctl, wr_len, wr_dat, push_ok, drop_full, pop_ok, done, flush;
   logic [LW-1:0] level;
   logic [LW:0]   lvl_nx;

   assign wr_ctl    = hst_we && (hst_addr == CTL_OFS);
   assign wr_len    = hst_we && (hst_addr == LEN_OFS);
   assign wr_dat    = hst_we && (hst_addr == DAT_OFS);
   assign push_ok   = wr_dat && go_q && !full_q;
   assign drop_full = wr_dat && go_q && full_q;
   assign flush     = done || (wr_ctl && go_q && !hst_wdata[GO_BIT]);
   assign lvl_nx    = (LW+1)'(level) + (LW+1)'(push_ok) - (LW+1)'(pop_ok);

   h2c_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .push(push_ok), .wdata(hst_wdata),
      .pop(pop_ok), .rdata(dma_data), .level(level)
   );

   h2c_req #(.DW(DW), .DEPTH(DEPTH), .GROUP(GROUP)) u_req (
      .clk(clk), .rst_n(rst_n), .flush(flush), .push_ok(push_ok),
      .mode_ok(dma_mode_ok), .dma_en(dma_en), .pop_req(dma_pop),
      .cnt_we(dma_cnt_we), .cnt_wdata(dma_cnt_wdata),
      .pop_ok(pop_ok), .dreq(dma_dreq), .done(done), .cnt_q(dma_count)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         len_q      <= '0;
         go_q       <= 1'b0;
         rv_q       <= 1'b0;
         ovf_q      <= 1'b0;
         full_q     <= 1'b0;
         xend_q     <= 1'b0;
         anom_ns_q  <= 1'b0;
         anom_len_q <= 1'b0;
      end else begin
         if (wr_len) len_q <= hst_wdata;
         if (done)        go_q <= 1'b0;
         else if (wr_ctl) go_q <= hst_wdata[GO_BIT];
         if (wr_ctl) rv_q <= hst_wdata[RV_BIT];
         if (wr_ctl && !go_q && hst_wdata[GO_BIT]) ovf_q <= 1'b0;
         else if (drop_full)                       ovf_q <= 1'b1;
         if (flush)                          full_q <= 1'b0;
         else if (lvl_nx == (LW+1)'(DEPTH))  full_q <= 1'b1;
         else if (lvl_nx == '0)              full_q <= 1'b0;
         if (dma_cnt_we) xend_q <= 1'b0;
         else if (done)  xend_q <= 1'b1;
         anom_ns_q  <= wr_dat && !go_q;
         anom_len_q <= dma_cnt_we && (dma_cnt_wdata != len_q);
      end
   end

   always_comb begin
      hst_rdata = '0;
      if (hst_addr == LEN_OFS) begin
         hst_rdata = len_q;
      end else if (hst_addr == CTL_OFS) begin
         hst_rdata[GO_BIT]   = go_q;
         hst_rdata[RV_BIT]   = rv_q;
         hst_rdata[OVF_BIT]  = ovf_q;
         hst_rdata[FULL_BIT] = full_q;
      end
   end

   assign xfer_end     = xend_q;
   assign rv_out       = rv_q;
   assign anom_nostart = anom_ns_q;
   assign anom_len     = anom_len_q;
endmodule

// File: rtl/h2c_req_bridge_chk.sv
module h2c_req_bridge_chk #(
   parameter int DW    = 16,
   parameter int AW    = 6,
   parameter int DEPTH = 8,
   parameter logic [AW-1:0] CTL_OFS = 'h06,
   parameter logic [AW-1:0] DAT_OFS = 'h12,
   localparam int LW = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          hst_we,
   input logic [AW-1:0] hst_addr,
   input logic [DW-1:0] hst_wdata,
   input logic          go_q,
   input logic          full_q,
   input logic          ovf_q,
   input logic          anom_nostart,
   input logic          dma_dreq,
   input logic [LW-1:0] level,
   input logic          pop_ok,
   input logic [DW-1:0] dma_count,
   input logic          dma_cnt_we,
   input logic          xfer_end
);
   AST_NOSTART_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_we && hst_addr == DAT_OFS && !go_q) |=> anom_nostart); // R2

   AST_FULL_AT_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
      (level == LW'(DEPTH)) |-> full_q); // R3

   AST_REQ_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      dma_dreq |-> (level != '0)); // R4

   AST_COUNT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && !dma_cnt_we && dma_count > DW'(1)) |=> (dma_count == $past(dma_count) - 1'b1)); // R5

   AST_DONE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_ok && !dma_cnt_we && dma_count == DW'(1)) |=> (!go_q && xfer_end && level == '0 && !dma_dreq)); // R6

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_we && hst_addr == DAT_OFS && go_q && full_q) |=> ovf_q); // R9

   AST_STOP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
      (hst_we && hst_addr == CTL_OFS && go_q && !hst_wdata[0]) |=> (!dma_dreq && level == '0)); // R10
endmodule

bind h2c_req_bridge h2c_req_bridge_chk #(
   .DW(DW), .AW(AW), .DEPTH(DEPTH), .CTL_OFS(CTL_OFS), .DAT_OFS(DAT_OFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
   .hst_wdata(hst_wdata), .go_q(go_q), .full_q(full_q), .ovf_q(ovf_q),
   .anom_nostart(anom_nostart), .dma_dreq(dma_dreq), .level(level),
   .pop_ok(pop_ok), .dma_count(dma_count), .dma_cnt_we(dma_cnt_we),
   .xfer_end(xfer_end)
);

// File: tb/h2c_req_bridge_bench.sv
module h2c_req_bridge_bench;
   localparam int CLK_PERIOD = 10;
   localparam logic [5:0] CTL = 6'h06, LEN = 6'h10, DAT = 6'h12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic hst_we = 1'b0;
   logic [5:0] hst_addr = '0;
   logic [15:0] hst_wdata = '0, hst_rdata;
   logic dma_mode_ok = 1'b1, dma_en = 1'b1, dma_cnt_we = 1'b0, dma_pop = 1'b0;
   logic [15:0] dma_cnt_wdata = '0, dma_count, dma_data;
   logic dma_dreq, xfer_end, rv_out, anom_nostart, anom_len;

   int checks = 0, errors = 0;
   logic [15:0] sb_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   h2c_req_bridge u_h2c_req_bridge (
      .clk(clk), .rst_n(rst_n), .hst_we(hst_we), .hst_addr(hst_addr),
      .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
      .dma_mode_ok(dma_mode_ok), .dma_en(dma_en),
      .dma_cnt_we(dma_cnt_we), .dma_cnt_wdata(dma_cnt_wdata),
      .dma_count(dma_count), .dma_pop(dma_pop), .dma_dreq(dma_dreq),
      .dma_data(dma_data), .xfer_end(xfer_end), .rv_out(rv_out),
      .anom_nostart(anom_nostart), .anom_len(anom_len)
   );

   task automatic chk(input logic ok, input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic chkv(input string req, input logic [15:0] act, input logic [15:0] exp);
      chk(act == exp, req, act, exp);
   endtask

   // monitor: compares each granted pop against the scoreboard
   always @(negedge clk) begin
      if (rst_n && dma_pop && dma_dreq) begin
         if (sb_q.size() == 0) begin
            chk(1'b0, "R4 pop with empty scoreboard", dma_data, 16'h0);
         end else begin
            chkv("R4 word order", dma_data, sb_q.pop_front());
         end
      end
   end

   task automatic hwr(input logic [5:0] a, input logic [15:0] d);
      hst_addr = a; hst_wdata = d; hst_we = 1'b1;
      @(posedge clk); #1;
      hst_we = 1'b0;
   endtask

   // driver: writes a data word and records it when it must be accepted
   task automatic put(input logic [15:0] d, input logic accept);
      if (accept) sb_q.push_back(d);
      hwr(DAT, d);
   endtask

   task automatic hrd(input logic [5:0] a, output logic [15:0] d);
      hst_addr = a; #1; d = hst_rdata;
   endtask

   task automatic pop(input int n);
      for (int i = 0; i < n; i++) begin
         dma_pop = 1'b1;
         @(posedge clk); #1;
      end
      dma_pop = 1'b0;
   endtask

   task automatic ldcnt(input logic [15:0] v);
      dma_cnt_wdata = v; dma_cnt_we = 1'b1;
      @(posedge clk); #1;
      dma_cnt_we = 1'b0;
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [15:0] rd;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      hrd(CTL, rd); chkv("R3 reset status", rd, 16'h0000);
      chkv("R4 reset dreq", 16'(dma_dreq), 16'h0);
      chkv("R5 reset count", dma_count, 16'h0);

      hwr(LEN, 16'd8);
      hrd(LEN, rd); chkv("R1 length readback", rd, 16'd8);

      put(16'hDEAD, 1'b0);
      chkv("R2 discard pulse", 16'(anom_nostart), 16'h1);

      ldcnt(16'd8);
      chkv("R7 no mismatch", 16'(anom_len), 16'h0);

      hwr(CTL, 16'h00C3);
      hrd(CTL, rd); chkv("R8 only run and routing bits", rd, 16'h0003);
      chkv("R8 rv_out", 16'(rv_out), 16'h1);

      for (int i = 0; i < 3; i++) put(16'h1000 + 16'(i), 1'b1);
      chkv("R4 no request before group", 16'(dma_dreq), 16'h0);
      put(16'h1003, 1'b1);
      chkv("R4 request after group", 16'(dma_dreq), 16'h1);

      for (int i = 4; i < 8; i++) put(16'h1000 + 16'(i), 1'b1);
      hrd(CTL, rd); chkv("R3 full at depth", rd, 16'h0083);
      put(16'hBAD0, 1'b0);
      hrd(CTL, rd); chkv("R9 overflow sticky", rd, 16'h00C3);

      pop(4);
      hrd(CTL, rd); chkv("R3 full held until empty", rd, 16'h00C3);
      chkv("R5 count after four pops", dma_count, 16'd4);
      pop(4);
      hrd(CTL, rd); chkv("R6 run bit cleared at end", rd, 16'h0042);
      chkv("R6 xfer_end", 16'(xfer_end), 16'h1);
      chkv("R6 dreq dropped", 16'(dma_dreq), 16'h0);

      ldcnt(16'd5);
      chkv("R7 mismatch pulse", 16'(anom_len), 16'h1);
      chkv("R6 xfer_end cleared by load", 16'(xfer_end), 16'h0);
      hwr(CTL, 16'h0001);
      hrd(CTL, rd); chkv("R9 overflow cleared on start", rd, 16'h0001);
      for (int i = 0; i < 4; i++) put(16'h2000 + 16'(i), 1'b1);
      pop(4);
      chkv("R5 count 1 left", dma_count, 16'd1);
      for (int i = 4; i < 8; i++) put(16'h2000 + 16'(i), 1'b1);
      pop(1);
      sb_q.delete();
      chkv("R7 transfer completes despite mismatch", 16'(xfer_end), 16'h1);
      chkv("R6 flush dreq", 16'(dma_dreq), 16'h0);
      hrd(CTL, rd); chkv("R6 status after mid-group end", rd, 16'h0000);

      hwr(LEN, 16'd4);
      ldcnt(16'd4);
      hwr(CTL, 16'h0001);
      for (int i = 0; i < 4; i++) put(16'h3000 + 16'(i), 1'b1);
      pop(4);
      chkv("R6 fresh data after flush", 16'(sb_q.size()), 16'h0);

      dma_mode_ok = 1'b0;
      ldcnt(16'd8);
      hwr(CTL, 16'h0001);
      for (int i = 0; i < 4; i++) put(16'h4000 + 16'(i), 1'b1);
      chkv("R11 no request without mode", 16'(dma_dreq), 16'h0);
      hwr(CTL, 16'h0000);
      sb_q.delete();
      dma_mode_ok = 1'b1;
      hwr(CTL, 16'h0001);
      for (int i = 0; i < 4; i++) put(16'h5000 + 16'(i), 1'b1);
      chkv("R10 request before stop", 16'(dma_dreq), 16'h1);
      hwr(CTL, 16'h0000);
      sb_q.delete();
      chkv("R10 request withdrawn", 16'(dma_dreq), 16'h0);
      hwr(CTL, 16'h0001);
      for (int i = 0; i < 4; i++) put(16'h6000 + 16'(i), 1'b1);
      pop(4);
      chkv("R10 only new words delivered", 16'(sb_q.size()), 16'h0);
      chkv("R5 count after restart", dma_count, 16'd4);

      finish_run();
   end
endmodule